// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block chooses which of up to fifteen pending transmit mailboxes is loaded next into a CAN controller's single transmit buffer. Software posts mailboxes by setting their pending bits. While idle, the scheduler picks one pending mailbox under one of two policies, chosen by an ordering input. With the input low, the mailbox with the numerically lowest 11-bit identifier wins, and a tie goes to the lower mailbox number. With the input high, the lowest mailbox number wins, whatever the identifiers are. The chosen index and identifier are offered to the transmit path until that path reports a result.

A successful transmission clears the mailbox's pending bit. A lost arbitration leaves it pending, and the scheduler chooses again from the pending set as it stands at that moment, so a message posted during the failed attempt can take over. A hold input, used for sleep or halt, stops new offers and keeps every pending bit. The same block also keeps one receive-complete flag and one remote-request flag per mailbox. Receiving a frame sets these flags, and writing 1 to a flag clears it.

Top module: `can_tx_sched`

## Requirements
- R1: A post cycle (`post_valid_i` high) sets the pending bit of every mailbox 1..15 whose `post_mask_i` bit is 1. Mailbox 0 never becomes pending and is never offered.
- R2: When idle, with `hold_i` low and at least one bit pending, `tx_req_o` rises on the next clock edge. The offered `tx_idx_o` is always a pending mailbox.
- R3: With `by_index_i` = 0, the offered mailbox has the numerically lowest identifier among the pending ones, and a tie goes to the lower mailbox number. `tx_id_o` carries that identifier.
- R4: With `by_index_i` = 1, the offered mailbox is the lowest-numbered pending one.
- R5: While `tx_req_o` is high and no result is reported, `tx_idx_o` and `tx_id_o` do not change.
- R6: `tx_done_i` during an offer clears that mailbox's pending bit and drops `tx_req_o` on the same edge. If a post of that same mailbox arrives in that cycle, the bit stays set.
- R7: `tx_lost_i` during an offer keeps the pending bit and drops `tx_req_o` for one cycle. The next offer is then chosen from the pending set current at that point.
- R8: While `hold_i` is high, no new offer starts and pending bits are kept.
- R9: `rx_valid_i` sets receive-complete flag `rx_idx_i`. When `rx_remote_i` is also high, it sets remote-request flag `rx_idx_i` as well.
- R10: A 1 in `rxc_clr_i` or `rr_clr_i` clears the corresponding flag, and a 0 leaves it unchanged. A set and a clear of the same flag in the same cycle leave the flag set.
- R11: After reset, pending bits and both flag sets are zero and `tx_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| by_index_i | input | 1 | Ordering: 0 by identifier, 1 by mailbox number |
| hold_i | input | 1 | Sleep/halt: blocks new offers |
| post_valid_i | input | 1 | Post strobe |
| post_mask_i | input | NUM_MB | Mailboxes to mark pending |
| ids_i | input | NUM_MB*ID_W | Identifier of mailbox i at bits [i*ID_W +: ID_W] |
| tx_req_o | output | 1 | Offer to the transmit path is active |
| tx_idx_o | output | IDX_W | Offered mailbox number |
| tx_id_o | output | ID_W | Identifier of the offered mailbox |
| tx_done_i | input | 1 | Offered frame was sent |
| tx_lost_i | input | 1 | Offered frame lost arbitration |
| pend_o | output | NUM_MB | Pending bits |
| rx_valid_i | input | 1 | A frame was received correctly |
| rx_idx_i | input | IDX_W | Mailbox that received the frame |
| rx_remote_i | input | 1 | The received frame was a remote frame |
| rxc_clr_i | input | NUM_MB | Write-1-to-clear mask for receive-complete flags |
| rr_clr_i | input | NUM_MB | Write-1-to-clear mask for remote-request flags |
| rxc_o | output | NUM_MB | Receive-complete flags |
| rr_o | output | NUM_MB | Remote-request flags |

## Verification
A corrupted pending bit shows on `pend_o` one edge after the post or result that caused it. Two edges later it shows again as a wrong offer, a missing offer or an extra offer. A wrong winner from the selection logic shows on the first offer after the choice, as a mismatch on `tx_idx_o` or `tx_id_o`. The scoreboard's model of the pending set catches that mismatch on the first new offer. A broken state register shows either as `tx_req_o` staying high after a result, or as an offer that starts while hold is asserted. The bench checks for both within one cycle. Flag errors show on `rxc_o` and `rr_o` one edge after the receive or clear that caused them.

// File: rtl/can_sched_pkg.sv
package can_sched_pkg;
  typedef enum logic {
    SCH_IDLE = 1'b0,
    SCH_BUSY = 1'b1
  } sch_state_e;
endpackage

// File: rtl/can_sched_pend.sv
// Per-mailbox pending register: post sets, a successful transmission clears.
module can_sched_pend #(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid_i,
  input  logic [NUM_MB-1:0] post_mask_i,
  input  logic              clr_valid_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  output logic [NUM_MB-1:0] pend_o
);
  logic [NUM_MB-1:0] pend_q;
  logic [NUM_MB-1:0] pend_d;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_bit
    logic set_c;
    logic clr_c;
    always_comb begin
      set_c     = post_valid_i && post_mask_i[i];
      clr_c     = clr_valid_i && (clr_idx_i == IDX_W'(i));
      pend_d[i] = set_c | (pend_q[i] & ~clr_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
      end else if (set_c || clr_c) begin
        pend_q[i] <= pend_d[i];
      end
    end

    // R1: a posted bit is visible after the edge
    a_r1_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_c |=> pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/can_sched_pick.sv
// Selection of the next mailbox under identifier or mailbox-number ordering.
module can_sched_pick #(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 11,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic [NUM_MB-1:0]      pend_i,
  input  logic [NUM_MB*ID_W-1:0] ids_i,
  input  logic                   by_index_i,
  output logic                   win_valid_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic [ID_W-1:0]        win_id_o
);
  always_comb begin
    logic [ID_W-1:0] cur;
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_id_o    = '0;
    // Ascending scan: the strict compare gives ties to the lower mailbox,
    // and in index mode the first pending mailbox found is kept.
    for (int i = 0; i < NUM_MB; i++) begin
      cur = ids_i[i*ID_W +: ID_W];
      if (pend_i[i] && (!win_valid_o || (!by_index_i && (cur < win_id_o)))) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_id_o    = cur;
      end
    end
  end
endmodule

// File: rtl/can_sched_flags.sv
// Receive-complete and remote-request flags, write-1-to-clear.
module can_sched_flags #(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid_i,
  input  logic [IDX_W-1:0]  rx_idx_i,
  input  logic              rx_remote_i,
  input  logic [NUM_MB-1:0] rxc_clr_i,
  input  logic [NUM_MB-1:0] rr_clr_i,
  output logic [NUM_MB-1:0] rxc_o,
  output logic [NUM_MB-1:0] rr_o
);
  logic [NUM_MB-1:0] rxc_q, rxc_d;
  logic [NUM_MB-1:0] rr_q,  rr_d;
  logic [NUM_MB-1:0] hit;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_flag
    always_comb begin
      hit[i]   = rx_valid_i && (rx_idx_i == IDX_W'(i));
      rxc_d[i] = hit[i] | (rxc_q[i] & ~rxc_clr_i[i]);
      rr_d[i]  = (hit[i] & rx_remote_i) | (rr_q[i] & ~rr_clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxc_q[i] <= 1'b0;
        rr_q[i]  <= 1'b0;
      end else begin
        if (hit[i] || rxc_clr_i[i]) rxc_q[i] <= rxc_d[i];
        if (hit[i] || rr_clr_i[i])  rr_q[i]  <= rr_d[i];
      end
    end
  end

  assign rxc_o = rxc_q;
  assign rr_o  = rr_q;

  a_r9_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> rxc_q[$past(rx_idx_i)]);
  a_r9_remote_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && rx_remote_i) |=> rr_q[$past(rx_idx_i)]);
  a_r10_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rxc_q & $past(rxc_q & ~rxc_clr_i)) == $past(rxc_q & ~rxc_clr_i)));
  a_r10_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rr_q & $past(rr_clr_i & ~hit)) == '0));
endmodule

// File: rtl/can_tx_sched.sv
// Top: offer state machine around the pending set, selector and flags.
module can_tx_sched
  import can_sched_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 11,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   by_index_i,
  input  logic                   hold_i,
  input  logic                   post_valid_i,
  input  logic [NUM_MB-1:0]      post_mask_i,
  input  logic [NUM_MB*ID_W-1:0] ids_i,
  output logic                   tx_req_o,
  output logic [IDX_W-1:0]       tx_idx_o,
  output logic [ID_W-1:0]        tx_id_o,
  input  logic                   tx_done_i,
  input  logic                   tx_lost_i,
  output logic [NUM_MB-1:0]      pend_o,
  input  logic                   rx_valid_i,
  input  logic [IDX_W-1:0]       rx_idx_i,
  input  logic                   rx_remote_i,
  input  logic [NUM_MB-1:0]      rxc_clr_i,
  input  logic [NUM_MB-1:0]      rr_clr_i,
  output logic [NUM_MB-1:0]      rxc_o,
  output logic [NUM_MB-1:0]      rr_o
);
  localparam logic [NUM_MB-1:0] TX_CAPABLE = ~NUM_MB'(1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sch_state_e        state_q, state_d;
  logic [IDX_W-1:0]  sel_idx_q, sel_idx_d;
  logic [ID_W-1:0]   sel_id_q,  sel_id_d;
  logic              load_en;
  logic              win_valid;
  logic [IDX_W-1:0]  win_idx;
  logic [ID_W-1:0]   win_id;
  logic [NUM_MB-1:0] pend;
  logic              sent;
  logic [NUM_MB-1:0] post_eff;

  assign post_eff = post_mask_i & TX_CAPABLE;
  assign sent     = (state_q == SCH_BUSY) && tx_done_i;

  can_sched_pend #(.NUM_MB(NUM_MB)) u_pend (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .post_valid_i (post_valid_i),
    .post_mask_i  (post_eff),
    .clr_valid_i  (sent),
    .clr_idx_i    (sel_idx_q),
    .pend_o       (pend)
  );

  can_sched_pick #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_pick (
    .pend_i      (pend),
    .ids_i       (ids_i),
    .by_index_i  (by_index_i),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_id_o    (win_id)
  );

  can_sched_flags #(.NUM_MB(NUM_MB)) u_flags (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .rx_valid_i  (rx_valid_i),
    .rx_idx_i    (rx_idx_i),
    .rx_remote_i (rx_remote_i),
    .rxc_clr_i   (rxc_clr_i),
    .rr_clr_i    (rr_clr_i),
    .rxc_o       (rxc_o),
    .rr_o        (rr_o)
  );

  // Next state
  always_comb begin
    state_d   = state_q;
    sel_idx_d = sel_idx_q;
    sel_id_d  = sel_id_q;
    load_en   = 1'b0;
    unique case (state_q)
      SCH_IDLE: begin
        if (!hold_i && win_valid) begin
          state_d   = SCH_BUSY;
          sel_idx_d = win_idx;
          sel_id_d  = win_id;
          load_en   = 1'b1;
        end
      end
      SCH_BUSY: begin
        if (tx_done_i || tx_lost_i) state_d = SCH_IDLE;
      end
      default: state_d = SCH_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= SCH_IDLE;
      sel_idx_q <= '0;
      sel_id_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_en) begin
        sel_idx_q <= sel_idx_d;
        sel_id_q  <= sel_id_d;
      end
    end
  end

  assign tx_req_o = (state_q == SCH_BUSY);
  assign tx_idx_o = sel_idx_q;
  assign tx_id_o  = sel_id_q;
  assign pend_o   = pend;

  a_r2_offer_pending: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_req_o |-> (pend[tx_idx_o] && (tx_idx_o != '0)));
  a_r5_offer_stable: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_req_o && !tx_done_i && !tx_lost_i) |=> (tx_req_o && $stable(tx_idx_o) && $stable(tx_id_o)));
  a_r6_done_releases: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_req_o && tx_done_i && !(post_valid_i && post_mask_i[tx_idx_o])) |=> (!tx_req_o && !pend[$past(tx_idx_o)]));
  a_r7_lost_keeps: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_req_o && tx_lost_i && !tx_done_i) |=> (!tx_req_o && pend[$past(tx_idx_o)]));
  a_r8_hold_blocks: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!tx_req_o && hold_i) |=> !tx_req_o);
endmodule

// File: tb/can_tx_sched_bench.sv
module can_tx_sched_bench;
  localparam int NMB = 16;
  localparam int IDW = 11;
  localparam int IXW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic by_index = 0, hold = 0, post_valid = 0;
  logic [NMB-1:0] post_mask = '0;
  logic [IDW-1:0] ids [NMB];
  logic [NMB*IDW-1:0] ids_flat;
  logic tx_req; logic [IXW-1:0] tx_idx; logic [IDW-1:0] tx_id;
  logic tx_done = 0, tx_lost = 0;
  logic [NMB-1:0] pend;
  logic rx_valid = 0, rx_remote = 0;
  logic [IXW-1:0] rx_idx = '0;
  logic [NMB-1:0] rxc_clr = '0, rr_clr = '0, rxc, rr;

  always_comb for (int i = 0; i < NMB; i++) ids_flat[i*IDW +: IDW] = ids[i];

  can_tx_sched u_can_tx_sched (
    .clk(clk), .rst_n(rst_n), .by_index_i(by_index), .hold_i(hold),
    .post_valid_i(post_valid), .post_mask_i(post_mask), .ids_i(ids_flat),
    .tx_req_o(tx_req), .tx_idx_o(tx_idx), .tx_id_o(tx_id),
    .tx_done_i(tx_done), .tx_lost_i(tx_lost), .pend_o(pend),
    .rx_valid_i(rx_valid), .rx_idx_i(rx_idx), .rx_remote_i(rx_remote),
    .rxc_clr_i(rxc_clr), .rr_clr_i(rr_clr), .rxc_o(rxc), .rr_o(rr));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [NMB-1:0] mdl = '0;
  int exp_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int winner(input logic [NMB-1:0] p, input logic byi);
    int w = -1;
    for (int i = 1; i < NMB; i++)
      if (p[i] && (w < 0 || (!byi && ids[i] < ids[w]))) w = i;
    return w;
  endfunction

  task automatic push_next();
    if (mdl != '0 && !hold) exp_q.push_back(winner(mdl, by_index));
  endtask

  task automatic post(input logic [NMB-1:0] m);
    @(negedge clk); post_valid = 1; post_mask = m;
    @(negedge clk); post_valid = 0; post_mask = '0;
    mdl |= m & ~NMB'(1);
  endtask

  // Monitor: every new offer is compared with the head of the expectation queue
  logic req_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_req && !req_prev) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected offer", tx_idx, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(tx_idx == IXW'(e), by_index ? "R4 offered index" : "R3 offered index", tx_idx, e);
          chk(tx_id == ids[e], "R3 offered identifier", tx_id, ids[e]);
        end
      end
      req_prev = tx_req;
    end
  end

  task automatic serve(input bit ok, input int hold_cyc, input logic [NMB-1:0] also);
    logic [IXW-1:0] first;
    while (!tx_req) @(negedge clk);
    first = tx_idx;
    for (int k = 0; k < hold_cyc; k++) begin
      @(negedge clk);
      chk(tx_req && tx_idx == first, "R5 offer held", tx_idx, first);
    end
    tx_done = ok; tx_lost = !ok;
    if (also != '0) begin post_valid = 1; post_mask = also; end
    @(negedge clk);
    tx_done = 0; tx_lost = 0; post_valid = 0; post_mask = '0;
    if (ok) mdl[first] = 1'b0;
    mdl |= also & ~NMB'(1);
    chk(!tx_req, ok ? "R6 request drops" : "R7 request drops", tx_req, 0);
    chk(pend == mdl, ok ? "R6 pending after result" : "R7 pending after loss", pend, mdl);
    push_next();
  endtask

  initial begin
    for (int i = 0; i < NMB; i++) ids[i] = IDW'(11'h600 - i * 8);
    ids[3] = 11'h300; ids[5] = 11'h120; ids[7] = 11'h400;
    ids[4] = 11'h050; ids[9] = 11'h050; ids[6] = 11'h200; ids[10] = 11'h010;
    ids[12] = 11'h001; ids[2] = 11'h7FF; ids[8] = 11'h100;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!tx_req, "R11 tx_req", tx_req, 0);
    chk(pend == '0, "R11 pending", pend, 0);
    chk(rxc == '0 && rr == '0, "R11 flags", {rxc, rr}, 0);

    // R3: identifier order 5(0x120), 3(0x300), 7(0x400)
    post(16'h00A8); push_next();
    serve(1, 3, '0); serve(1, 0, '0); serve(1, 1, '0);
    // R3: equal identifiers, lower mailbox first
    post(16'h0210); push_next();
    serve(1, 0, '0); serve(1, 0, '0);

    // R4: mailbox order ignores identifiers
    @(negedge clk); by_index = 1;
    post(16'h1104); push_next();
    serve(1, 0, '0); serve(1, 2, '0); serve(1, 0, '0);
    @(negedge clk); by_index = 0;

    // R7: loss with a higher-priority post arriving meanwhile
    post(16'h0040); push_next();
    serve(0, 2, 16'h0400);
    serve(1, 0, '0); serve(1, 0, '0);

    // R8: hold keeps pending and blocks offers
    @(negedge clk); hold = 1;
    post(16'h0800);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!tx_req, "R8 no offer under hold", tx_req, 0);
    end
    chk(pend[11], "R8 pending kept", pend, 16'h0800);
    hold = 0; push_next();
    serve(1, 0, '0);

    // R1: mailbox 0 cannot be posted
    post(16'h0001);
    repeat (3) @(negedge clk);
    chk(pend == '0 && !tx_req, "R1 mailbox 0 ignored", pend, 0);

    // R6: done and repost of the same mailbox in one cycle
    post(16'h2000); push_next();
    serve(1, 0, 16'h2000);
    serve(1, 0, '0);

    // R9: receive flags
    @(negedge clk); rx_valid = 1; rx_idx = 4; rx_remote = 0;
    @(negedge clk); rx_idx = 7; rx_remote = 1;
    @(negedge clk); rx_valid = 0; rx_remote = 0;
    chk(rxc == 16'h0090, "R9 receive-complete", rxc, 16'h0090);
    chk(rr == 16'h0080, "R9 remote-request", rr, 16'h0080);
    // R10: write-1 clears, zero bits keep
    rxc_clr = 16'h0010;
    @(negedge clk); rxc_clr = '0;
    chk(rxc == 16'h0080, "R10 clear one flag", rxc, 16'h0080);
    // R10: set and clear together keep the flag
    rx_valid = 1; rx_idx = 7; rx_remote = 1; rr_clr = 16'h0080;
    @(negedge clk); rx_valid = 0; rx_remote = 0; rr_clr = '0;
    chk(rr == 16'h0080, "R10 set beats clear", rr, 16'h0080);
    rr_clr = 16'hFFFF;
    @(negedge clk); rr_clr = '0;
    chk(rr == '0 && rxc == 16'h0080, "R10 clear remote", {rxc, rr}, 32'h0080_0000);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected offers seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule